// File: doc/BRIEF.md
# Cycle-Steal Data Channel Bridge

This block sits on a host bus as a slave and turns host reads and writes into cycle-steal transfers on the data channel of a second processor. Any host access whose address lands in a fixed 4K-word window raises a break request toward the channel. The request carries a 15-bit channel address. Its low 12 bits are the host word offset inside the window and its top 3 bits come from a block register, which selects one of eight 4K-word blocks in the second processor's memory.

Once the channel accepts the break and the address, the bridge delivers the write data or collects the read data. It uses the channel's data-accepted and data-available strobes, but only while the second processor reports that it is in its break state. It then completes the host cycle with a one-cycle acknowledge. If an awaited strobe never arrives, a programmable timeout ends the host cycle with an error pulse instead of an acknowledge, and a sticky timeout flag is set. The bridge only moves data. It has no way to start, stop or steer the second processor.

The host holds `hst_sel` and its address, direction and data steady until it sees `hst_ack` or `hst_err`. Only one transfer is in flight at a time.

Top module: `cs_channel_bridge`

## Requirements
- R1: A host access (`hst_sel` high) whose byte-address bits [17:13] equal 6 raises `ch_brk_req` one clock later.
- R2: An access outside that window that is not aimed at the block-register address produces no `ch_brk_req`, no `hst_ack` and no `hst_err`.
- R3: While `ch_brk_req` is high, `ch_addr` equals {block register[2:0], host address[12:1]} and stays stable.
- R4: The block register sits at byte address 0x3FFF0, resets to 0 and stores `hst_wdata[2:0]`. Reads return it zero-extended in `hst_rdata`. Either access is acknowledged with `hst_ack` one clock after `hst_sel`.
- R5: `ch_dir` is 1 for a host write (data into the channel) and 0 for a host read. `ch_dout` is zero whenever `ch_dir` is 0.
- R6: `ch_brk_req` stays high until `ch_brk_acpt` is sampled and drops on the following clock.
- R7: On a write, `ch_dout` carries the host write data from the clock after the break is accepted. `hst_ack` pulses for one clock, one clock after `ch_data_acpt` is sampled.
- R8: On a read, `hst_rdata` takes `ch_din` on the clock at which `ch_data_avail` is sampled, and `hst_ack` pulses in that same following clock.
- R9: `ch_data_acpt` and `ch_data_avail` are ignored while `ch_brk_state_n` is high.
- R10: If the awaited strobe of a phase is missing for `tmo_limit`+1 clocks, the host cycle ends with a one-clock `hst_err` and no `hst_ack`. `tmo_flag` is then set until the next window access is started.
- R11: After `hst_ack` or `hst_err`, nothing new starts until `hst_sel` has been low for at least one clock.
- R12: In and straight after reset, `ch_brk_req`, `ch_dir`, `ch_addr`, `ch_dout`, `hst_ack`, `hst_err` and `tmo_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_sel | input | 1 | Host access strobe, held until acknowledge or error |
| hst_wr | input | 1 | 1 = host write, 0 = host read |
| hst_addr | input | 18 | Host byte address |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, valid with `hst_ack` |
| hst_ack | output | 1 | One-clock completion pulse |
| hst_err | output | 1 | One-clock timeout completion pulse |
| tmo_limit | input | 8 | Timeout limit in clocks |
| tmo_flag | output | 1 | Sticky timeout indication |
| ch_brk_req | output | 1 | Break request to the channel |
| ch_addr | output | 15 | Channel word address |
| ch_dir | output | 1 | 1 = into channel, 0 = out of channel |
| ch_dout | output | 16 | Data toward the channel |
| ch_din | input | 16 | Data from the channel |
| ch_brk_acpt | input | 1 | Break and address accepted strobe |
| ch_data_acpt | input | 1 | Data accepted strobe |
| ch_data_avail | input | 1 | Data available strobe |
| ch_brk_state_n | input | 1 | Low while the second processor is in its break state |

## Verification
The assertions check several rules on every cycle. A break request only ever rises after a selected window access. It holds until accepted or timed out and drops right after acceptance. The channel address is stable while requested. Acknowledge and error never coincide, and acknowledge is a single pulse. Outgoing data stays zero on reads. The bench scenarios cover the rest, because those behaviours depend on values only the stimulus knows: the exact address assembly across every block value and several offsets, the window decode across all 32 upper-address blocks, data round trips and strobe gating by the break-state input. They also cover the exact timeout latency in both handshake phases and the flag's clearing.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_WDATA = 3'd2,
    ST_RDATA = 3'd3,
    ST_DONE  = 3'd4,
    ST_REG   = 3'd5,
    ST_ERR   = 3'd6,
    ST_REL   = 3'd7
  } brg_state_t;
endpackage

// File: rtl/bridge_decode.sv
module bridge_decode #(
  parameter int HA_W     = 18,
  parameter int BLK_W    = 3,
  parameter int OFS_W    = 12,
  parameter int WIN_BLK  = 6,
  parameter logic [HA_W-1:0] REG_ADDR = 18'h3FFF0,
  localparam int CA_W    = OFS_W + BLK_W,
  localparam int TAG_W   = HA_W - OFS_W - 1
) (
  input  logic [HA_W-1:0]  addr,
  input  logic [BLK_W-1:0] blk,
  output logic             hit_win,
  output logic             hit_reg,
  output logic [CA_W-1:0]  chan_addr
);
  function automatic logic in_window(input logic [HA_W-1:0] a);
    return a[HA_W-1:OFS_W+1] == TAG_W'(WIN_BLK);
  endfunction

  function automatic logic [CA_W-1:0] make_chan_addr(input logic [BLK_W-1:0] b,
                                                     input logic [HA_W-1:0] a);
    return {b, a[OFS_W:1]};
  endfunction

  assign hit_win   = in_window(addr);
  assign hit_reg   = (addr == REG_ADDR) && !in_window(addr);
  assign chan_addr = make_chan_addr(blk, addr);
endmodule

// File: rtl/bridge_blkreg.sv
module bridge_blkreg #(
  parameter int BLK_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [BLK_W-1:0] wval,
  output logic [BLK_W-1:0] blk
);
  always_ff @(posedge clk) begin
    if (!rst_n)  blk <= '0;
    else if (we) blk <= wval;
  end
endmodule

// File: rtl/bridge_seq.sv
module bridge_seq
  import bridge_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr,
  input  logic             hit_win,
  input  logic             hit_reg,
  input  logic             brk_acpt,
  input  logic             data_acpt,
  input  logic             data_avail,
  input  logic             brk_state_n,
  input  logic [TMO_W-1:0] tmo_limit,
  output brg_state_t       state,
  output logic             dir,
  output logic             start_xfer,
  output logic             reg_go,
  output logic             rd_cap,
  output logic             tmo_hit,
  output logic             tmo_flag
);
  logic [TMO_W-1:0] cnt;
  logic             waiting;
  logic             advance;
  logic             in_break;

  assign in_break   = !brk_state_n;
  assign waiting    = (state == ST_REQ) || (state == ST_WDATA) || (state == ST_RDATA);
  always_comb begin
    case (state)
      ST_REQ:   advance = brk_acpt;
      ST_WDATA: advance = data_acpt && in_break;
      ST_RDATA: advance = data_avail && in_break;
      default:  advance = 1'b0;
    endcase
  end
  assign tmo_hit    = waiting && !advance && (cnt >= tmo_limit);
  assign start_xfer = (state == ST_IDLE) && sel && hit_win;
  assign reg_go     = (state == ST_IDLE) && sel && hit_reg && !hit_win;
  assign rd_cap     = (state == ST_RDATA) && advance;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      dir      <= 1'b0;
      tmo_flag <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start_xfer) begin
            state    <= ST_REQ;
            dir      <= wr;
            tmo_flag <= 1'b0;
          end else if (reg_go) begin
            state <= ST_REG;
          end
        end
        ST_REQ, ST_WDATA, ST_RDATA: begin
          if (advance) begin
            cnt <= '0;
            if (state == ST_REQ) state <= dir ? ST_WDATA : ST_RDATA;
            else                 state <= ST_DONE;
          end else if (tmo_hit) begin
            state    <= ST_ERR;
            tmo_flag <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DONE, ST_REG, ST_ERR: state <= ST_REL;
        ST_REL:  if (!sel) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cs_channel_bridge.sv
module cs_channel_bridge
  import bridge_pkg::*;
#(
  parameter int HA_W    = 18,
  parameter int DW      = 16,
  parameter int BLK_W   = 3,
  parameter int OFS_W   = 12,
  parameter int TMO_W   = 8,
  parameter int WIN_BLK = 6,
  parameter logic [HA_W-1:0] REG_ADDR = 18'h3FFF0,
  localparam int CA_W   = OFS_W + BLK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hst_sel,
  input  logic             hst_wr,
  input  logic [HA_W-1:0]  hst_addr,
  input  logic [DW-1:0]    hst_wdata,
  output logic [DW-1:0]    hst_rdata,
  output logic             hst_ack,
  output logic             hst_err,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             tmo_flag,
  output logic             ch_brk_req,
  output logic [CA_W-1:0]  ch_addr,
  output logic             ch_dir,
  output logic [DW-1:0]    ch_dout,
  input  logic [DW-1:0]    ch_din,
  input  logic             ch_brk_acpt,
  input  logic             ch_data_acpt,
  input  logic             ch_data_avail,
  input  logic             ch_brk_state_n
);
  logic             hit_win;
  logic             hit_reg;
  logic [CA_W-1:0]  chan_addr;
  logic [BLK_W-1:0] blk;
  brg_state_t       state;
  logic             dir;
  logic             start_xfer;
  logic             reg_go;
  logic             rd_cap;
  logic             tmo_hit;
  logic [DW-1:0]    wdata_q;
  logic [CA_W-1:0]  addr_q;
  logic [DW-1:0]    rdata_q;

  bridge_decode #(
    .HA_W(HA_W), .BLK_W(BLK_W), .OFS_W(OFS_W),
    .WIN_BLK(WIN_BLK), .REG_ADDR(REG_ADDR)
  ) u_dec (
    .addr(hst_addr), .blk(blk),
    .hit_win(hit_win), .hit_reg(hit_reg), .chan_addr(chan_addr)
  );

  bridge_blkreg #(.BLK_W(BLK_W)) u_blk (
    .clk(clk), .rst_n(rst_n),
    .we(reg_go && hst_wr), .wval(hst_wdata[BLK_W-1:0]), .blk(blk)
  );

  bridge_seq #(.TMO_W(TMO_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .sel(hst_sel), .wr(hst_wr), .hit_win(hit_win), .hit_reg(hit_reg),
    .brk_acpt(ch_brk_acpt), .data_acpt(ch_data_acpt),
    .data_avail(ch_data_avail), .brk_state_n(ch_brk_state_n),
    .tmo_limit(tmo_limit),
    .state(state), .dir(dir), .start_xfer(start_xfer), .reg_go(reg_go),
    .rd_cap(rd_cap), .tmo_hit(tmo_hit), .tmo_flag(tmo_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wdata_q <= '0;
      addr_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (start_xfer) begin
        wdata_q <= hst_wdata;
        addr_q  <= chan_addr;
      end
      if (rd_cap)      rdata_q <= ch_din;
      else if (reg_go) rdata_q <= DW'(blk);
    end
  end

  assign ch_brk_req = (state == ST_REQ);
  assign ch_addr    = addr_q;
  assign ch_dir     = dir;
  assign ch_dout    = (state == ST_WDATA) ? wdata_q : '0;
  assign hst_ack    = (state == ST_DONE) || (state == ST_REG);
  assign hst_err    = (state == ST_ERR);
  assign hst_rdata  = rdata_q;
endmodule

// File: rtl/bridge_chk.sv
module bridge_chk #(
  parameter int DW   = 16,
  parameter int CA_W = 15
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hst_sel,
  input logic            hit_win,
  input logic            ch_brk_req,
  input logic            ch_brk_acpt,
  input logic [CA_W-1:0] ch_addr,
  input logic            ch_dir,
  input logic [DW-1:0]   ch_dout,
  input logic            hst_ack,
  input logic            hst_err,
  input logic            tmo_hit
);
  AST_REQ_FROM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_brk_req) |-> ($past(hst_sel) && $past(hit_win))); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_brk_req && !ch_brk_acpt && !tmo_hit) |=> ch_brk_req); // R6
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_brk_req && ch_brk_acpt) |=> !ch_brk_req); // R6
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_brk_req && $past(ch_brk_req)) |-> $stable(ch_addr)); // R3
  AST_READ_DOUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_dir |-> (ch_dout == '0)); // R5
  AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(hst_ack && hst_err)); // R10
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hst_ack |=> !hst_ack); // R11
endmodule

bind cs_channel_bridge bridge_chk #(.DW(DW), .CA_W(CA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hit_win(hit_win),
  .ch_brk_req(ch_brk_req), .ch_brk_acpt(ch_brk_acpt), .ch_addr(ch_addr),
  .ch_dir(ch_dir), .ch_dout(ch_dout), .hst_ack(hst_ack), .hst_err(hst_err),
  .tmo_hit(tmo_hit)
);

// File: tb/tb_cs_channel_bridge.sv
module tb_cs_channel_bridge;
  localparam int CLK_PERIOD = 10;
  localparam logic [17:0] REG_A = 18'h3FFF0;
  localparam int TMO = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_sel = 1'b0, hst_wr = 1'b0;
  logic [17:0] hst_addr = '0;
  logic [15:0] hst_wdata = '0, hst_rdata;
  logic        hst_ack, hst_err, tmo_flag;
  logic [7:0]  tmo_limit = 8'(TMO);
  logic        ch_brk_req, ch_dir;
  logic [14:0] ch_addr;
  logic [15:0] ch_dout, ch_din = '0;
  logic        ch_brk_acpt = 1'b0, ch_data_acpt = 1'b0, ch_data_avail = 1'b0;
  logic        ch_brk_state_n = 1'b1;

  int total = 0, bad = 0, cyc = 0;

  cs_channel_bridge dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<150000", cyc);
      summary();
    end
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic release_sel();
    hst_sel = 1'b0; step();
  endtask

  function automatic logic [17:0] win_addr(input logic [11:0] ofs);
    return {5'd6, ofs, 1'b0};
  endfunction

  task automatic reg_write(input logic [2:0] v);
    hst_sel = 1; hst_wr = 1; hst_addr = REG_A; hst_wdata = {13'h1ABC, v};
    step(); check("R4 reg write ack", hst_ack, 1);
    step(); check("R4 ack one pulse", hst_ack, 0);
    release_sel();
  endtask

  task automatic reg_read(input logic [2:0] v);
    hst_sel = 1; hst_wr = 0; hst_addr = REG_A;
    step(); check("R4 reg read ack", hst_ack, 1);
    check("R4 reg read value", hst_rdata, {13'h0, v});
    step(); release_sel();
  endtask

  // write transfer; gate_test first offers data_acpt outside break state
  task automatic xfer_write(input logic [11:0] ofs, input logic [2:0] b,
                            input logic [15:0] d, input int acpt_dly, input bit gate_test);
    hst_sel = 1; hst_wr = 1; hst_addr = win_addr(ofs); hst_wdata = d;
    step();
    check("R1 brk_req raised", ch_brk_req, 1);
    check("R3 channel address", ch_addr, {b, ofs});
    check("R5 dir write", ch_dir, 1);
    check("R10 flag cleared on start", tmo_flag, 0);
    for (int i = 0; i < acpt_dly; i++) begin
      step(); check("R6 brk_req held", ch_brk_req, 1);
    end
    ch_brk_acpt = 1; step(); ch_brk_acpt = 0;
    check("R6 brk_req dropped", ch_brk_req, 0);
    check("R7 dout after accept", ch_dout, d);
    if (gate_test) begin
      ch_data_acpt = 1; ch_brk_state_n = 1; step();
      ch_data_acpt = 0;
      check("R9 data_acpt ignored", hst_ack, 0);
      check("R9 still driving", ch_dout, d);
    end
    ch_brk_state_n = 0; ch_data_acpt = 1; step();
    ch_data_acpt = 0; ch_brk_state_n = 1;
    check("R7 write ack", hst_ack, 1);
    check("R7 no err", hst_err, 0);
    step(); check("R7 ack single pulse", hst_ack, 0);
    release_sel();
  endtask

  task automatic xfer_read(input logic [11:0] ofs, input logic [2:0] b,
                           input logic [15:0] d, input bit gate_test);
    hst_sel = 1; hst_wr = 0; hst_addr = win_addr(ofs);
    step();
    check("R1 brk_req raised rd", ch_brk_req, 1);
    check("R3 channel address rd", ch_addr, {b, ofs});
    check("R5 dir read", ch_dir, 0);
    ch_brk_acpt = 1; step(); ch_brk_acpt = 0;
    check("R5 dout zero on read", ch_dout, 0);
    if (gate_test) begin
      ch_din = ~d; ch_data_avail = 1; ch_brk_state_n = 1; step();
      ch_data_avail = 0;
      check("R9 data_avail ignored", hst_ack, 0);
    end
    ch_din = d; ch_data_avail = 1; ch_brk_state_n = 0; step();
    ch_data_avail = 0; ch_brk_state_n = 1; ch_din = '0;
    check("R8 read ack", hst_ack, 1);
    check("R8 read data", hst_rdata, d);
    step(); release_sel();
  endtask

  initial begin
    step(); step();
    check("R12 reset brk_req", ch_brk_req, 0);
    check("R12 reset ack/err", {hst_ack, hst_err}, 0);
    check("R12 reset dir/flag", {ch_dir, tmo_flag}, 0);
    check("R12 reset addr/dout", {ch_addr, ch_dout}, 0);
    rst_n = 1; step();
    check("R12 after reset", {ch_brk_req, hst_ack, hst_err, tmo_flag}, 0);
    reg_read(3'd0);

    // block register and address assembly across all blocks
    for (int b = 0; b < 8; b++) begin
      reg_write(3'(b));
      reg_read(3'(b));
      xfer_write(12'h000, 3'(b), 16'(16'h1111 * b + 1), b % 3, b == 2);
      xfer_write(12'hFFF, 3'(b), 16'(16'hA5A5 ^ b), 0, 0);
      xfer_read(12'(12'h123 * b + 7), 3'(b), 16'(16'h5A00 + b), b == 5);
    end

    // window decode sweep over all upper address blocks
    reg_write(3'd4);
    for (int t = 0; t < 32; t++) begin
      if (t == 6) begin
        xfer_write(12'hAAA, 3'd4, 16'hBEEF, 0, 0);
      end else begin
        hst_sel = 1; hst_wr = t[0]; hst_addr = {5'(t), 13'h0AAA};
        for (int k = 0; k < 3; k++) begin
          step();
          check("R2 outside window ignored", {ch_brk_req, hst_ack, hst_err}, 0);
        end
        release_sel();
      end
    end

    // R11: holding select after completion starts nothing
    hst_sel = 1; hst_wr = 0; hst_addr = win_addr(12'h010);
    step(); ch_brk_acpt = 1; step(); ch_brk_acpt = 0;
    ch_din = 16'h7777; ch_data_avail = 1; ch_brk_state_n = 0; step();
    ch_data_avail = 0; ch_brk_state_n = 1;
    check("R8 ack before hold", hst_ack, 1);
    for (int k = 0; k < 4; k++) begin
      step(); check("R11 no restart while sel held", {ch_brk_req, hst_ack}, 0);
    end
    release_sel();

    // R10: timeout in request phase
    hst_sel = 1; hst_wr = 1; hst_addr = win_addr(12'h055); hst_wdata = 16'h0F0F;
    for (int k = 1; k <= TMO + 1; k++) begin
      step(); check("R10 req held before timeout", {ch_brk_req, hst_err}, 2'b10);
    end
    step();
    check("R10 err pulse", {hst_err, hst_ack, ch_brk_req}, 3'b100);
    check("R10 flag set", tmo_flag, 1);
    step(); check("R10 err single", hst_err, 0);
    release_sel();

    // R10: timeout in data phase
    hst_sel = 1; hst_wr = 1; hst_addr = win_addr(12'h066);
    step(); ch_brk_acpt = 1; step(); ch_brk_acpt = 0;
    for (int k = 2; k <= TMO + 1; k++) begin
      step(); check("R10 waiting data", {hst_err, hst_ack}, 0);
    end
    step();
    check("R10 data-phase err", {hst_err, hst_ack}, 2'b10);
    step(); release_sel();
    check("R10 flag sticky", tmo_flag, 1);
    xfer_read(12'h077, 3'd4, 16'hC3C3, 0);
    check("R10 flag stays clear", tmo_flag, 0);

    summary();
  end
endmodule